// File: doc/BRIEF.md
# Processor Interrupt Unit with System Registers

This unit sits next to a processor pipeline and owns the state that governs interrupts. It keeps four system registers: a control/status word, the handler entry address, the saved return address and the number of the cause that was last accepted. Device request lines are level-sensitive. A fixed-priority encoder picks the winning source, and when interrupts are enabled the unit takes the interrupt. It saves the resume address, records the cause, disables further interrupts and redirects fetch to the handler.

The pipeline presents system instructions to the unit as decoded strobes carrying a register number and write data. There are three of them: read a system register, write a system register, and return from interrupt. The return restores the previous enable state and redirects fetch to the saved address. Pipeline slots that hold bubbles are flagged. The unit remembers the next-PC of the most recent real instruction, so a bubble never supplies the resume address.

The instruction encoding is decoded by the pipeline: major opcode 4'hF selects the system group, and secondary opcode 1, 2 or 3 selects return, read or write. The unit sees only the resulting strobes.

Top module: `irq_sysctl`

## Requirements
- R1: After synchronous reset, the control/status word, handler address and return address are zero, the cause register holds 15 (no cause), and redirect_valid is low.
- R2: System register numbers are 0 control/status, 1 handler address, 2 return address and 3 cause. Control/status bit 0 is the interrupt enable (IE) and bit 1 is the saved enable (OIE), and its other bits read as zero. Numbers 4 to 15 read as zero, and writes to them change nothing.
- R3: An interrupt is taken in a cycle when IE is 1, at least one request line is high, and neither a write nor a return strobe is present in that cycle.
- R4: On taking an interrupt, OIE receives the old IE and IE becomes 0.
- R5: Request bit i has cause number i+1, and the lowest index wins (bit 0 timer = 1, bit 1 keys = 2, bit 2 switches = 3). The winning number is loaded into the cause register on entry.
- R6: On entry, the return address register receives slot_next_pc if slot_valid is high. Otherwise it receives the next-PC of the last valid slot, or RESET_PC if no slot has been valid since reset.
- R7: In the cycle after an interrupt is taken, redirect_valid is high for that cycle and redirect_pc equals the handler address as it was before the edge.
- R8: A return strobe copies OIE into IE, leaves OIE unchanged, and in the next cycle raises redirect_valid with redirect_pc equal to the return address. A return strobe takes precedence over a write strobe in the same cycle.
- R9: A write that clears IE in the same cycle as an active request prevents the interrupt. While IE is 0, a request that stays high never causes a redirect.
- R10: A read strobe makes rsr_data show, one cycle later, the selected register's value from before that edge. Without a read strobe, rsr_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | NSRC | Level-sensitive device requests, bit 0 highest priority |
| slot_valid | input | 1 | Current slot holds a real instruction (not a bubble) |
| slot_next_pc | input | DW | Next-instruction address of the current slot |
| rsr_en | input | 1 | Read-system-register strobe |
| wsr_en | input | 1 | Write-system-register strobe |
| reti_en | input | 1 | Return-from-interrupt strobe |
| sreg_sel | input | 4 | System register number for read or write |
| wsr_data | input | DW | Write data |
| rsr_data | output | DW | Registered read result |
| redirect_valid | output | 1 | Fetch redirect request, one cycle |
| redirect_pc | output | DW | Fetch redirect target |

## Verification
On every cycle, the assertions check the entry update of the enable bits, the choice of cause against the lowest active request, the redirect target after entry and after return, the tracking of the last valid next-PC, and the absence of a redirect while IE is low. Only the bench scenarios can show the following behaviours: reset values read back through the read port, reserved numbers that read zero after a write, a bubble slot supplying a stale resume address, and a write that clears IE winning against a pending request. Long random runs of mixed strobes and requests compare every output against a bench-side reference model.

// File: rtl/irq_sysctl_pkg.sv
package irq_sysctl_pkg;
  localparam int SEL_W   = 4;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'hF;
  localparam int PCS_IE  = 0;
  localparam int PCS_OIE = 1;

  typedef enum logic [SEL_W-1:0] {
    SR_PCS     = 4'd0,
    SR_HANDLER = 4'd1,
    SR_RETADDR = 4'd2,
    SR_CAUSE   = 4'd3
  } sreg_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_sysctl_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0]    req,
  output logic               any,
  output logic [CAUSE_W-1:0] code
);
  // chain[i] holds the winning code among sources i..NSRC-1
  logic [CAUSE_W-1:0] chain [NSRC+1];
  assign chain[NSRC] = CAUSE_NONE;

  for (genvar i = NSRC - 1; i >= 0; i--) begin : g_stage
    assign chain[i] = req[i] ? CAUSE_W'(i + 1) : chain[i+1];
  end

  assign code = chain[0];
  assign any  = |req;
endmodule

// File: rtl/irq_ret_tracker.sv
module irq_ret_tracker #(
  parameter int DW = 32,
  parameter logic [DW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_valid,
  input  logic [DW-1:0] slot_next_pc,
  output logic [DW-1:0] ret_pc
);
  logic [DW-1:0] last_pc;

  always_ff @(posedge clk) begin
    if (rst)             last_pc <= RESET_PC;
    else if (slot_valid) last_pc <= slot_next_pc;
  end

  assign ret_pc = slot_valid ? slot_next_pc : last_pc;

  a_r6_track_valid_pc: assert property (@(posedge clk) disable iff (rst)
    slot_valid |=> last_pc == $past(slot_next_pc));
  a_r6_hold_on_bubble: assert property (@(posedge clk) disable iff (rst)
    !slot_valid |=> $stable(last_pc));
endmodule

// File: rtl/irq_sysctl.sv
module irq_sysctl
  import irq_sysctl_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSRC = 3,
  parameter logic [DW-1:0] RESET_PC = 32'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  dev_irq,
  input  logic             slot_valid,
  input  logic [DW-1:0]    slot_next_pc,
  input  logic             rsr_en,
  input  logic             wsr_en,
  input  logic             reti_en,
  input  logic [SEL_W-1:0] sreg_sel,
  input  logic [DW-1:0]    wsr_data,
  output logic [DW-1:0]    rsr_data,
  output logic             redirect_valid,
  output logic [DW-1:0]    redirect_pc
);
  logic               ie, oie;
  logic [DW-1:0]      iha, ira;
  logic [CAUSE_W-1:0] idn;
  logic               any_req;
  logic [CAUSE_W-1:0] cause;
  logic [DW-1:0]      ret_pc;
  logic               take;
  logic [DW-1:0]      rd_val;

  irq_prio_enc #(.NSRC(NSRC)) u_enc (
    .req (dev_irq),
    .any (any_req),
    .code(cause)
  );

  irq_ret_tracker #(.DW(DW), .RESET_PC(RESET_PC)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .slot_valid  (slot_valid),
    .slot_next_pc(slot_next_pc),
    .ret_pc      (ret_pc)
  );

  // System ops in flight defer entry; a level request is retried next cycle.
  assign take = ie && any_req && !wsr_en && !reti_en;

  always_comb begin
    rd_val = '0;
    case (sreg_sel)
      SR_PCS:     begin rd_val[PCS_IE] = ie; rd_val[PCS_OIE] = oie; end
      SR_HANDLER: rd_val = iha;
      SR_RETADDR: rd_val = ira;
      SR_CAUSE:   rd_val = DW'(idn);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie             <= 1'b0;
      oie            <= 1'b0;
      iha            <= '0;
      ira            <= '0;
      idn            <= CAUSE_NONE;
      rsr_data       <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= take || reti_en;
      redirect_pc    <= take ? iha : ira;
      rsr_data       <= rsr_en ? rd_val : '0;
      if (take) begin
        oie <= ie;
        ie  <= 1'b0;
        ira <= ret_pc;
        idn <= cause;
      end else if (reti_en) begin
        ie <= oie;
      end else if (wsr_en) begin
        case (sreg_sel)
          SR_PCS:     begin ie <= wsr_data[PCS_IE]; oie <= wsr_data[PCS_OIE]; end
          SR_HANDLER: iha <= wsr_data;
          SR_RETADDR: ira <= wsr_data;
          SR_CAUSE:   idn <= wsr_data[CAUSE_W-1:0];
          default:    ;
        endcase
      end
    end
  end

  // Assertion-side copy of the requests for checking the winner.
  logic [NSRC-1:0] dev_prev;
  always_ff @(posedge clk) dev_prev <= dev_irq;

  function automatic logic winner_ok(logic [NSRC-1:0] d, logic [CAUSE_W-1:0] c);
    for (int i = 0; i < NSRC; i++) begin
      if (d[i]) return int'(c) == i + 1;
    end
    return 1'b0;
  endfunction

  a_r4_entry_saves_ie: assert property (@(posedge clk) disable iff (rst)
    take |=> !ie && oie);
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    take |=> winner_ok(dev_prev, idn));
  a_r7_redirect_handler: assert property (@(posedge clk) disable iff (rst)
    take |=> redirect_valid && redirect_pc == $past(iha));
  a_r8_return_restores: assert property (@(posedge clk) disable iff (rst)
    reti_en |=> ie == $past(oie) && oie == $past(oie) && redirect_pc == $past(ira));
  a_r9_no_entry_when_off: assert property (@(posedge clk) disable iff (rst)
    (!ie && !reti_en) |=> !redirect_valid);
endmodule

// File: tb/test_irq_sysctl.sv
module test_irq_sysctl;
  localparam int DW = 32;
  localparam int NSRC = 3;
  localparam logic [DW-1:0] RPC = 32'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] dev_irq = '0;
  logic slot_valid = 1'b0;
  logic [DW-1:0] slot_next_pc = '0;
  logic rsr_en = 1'b0, wsr_en = 1'b0, reti_en = 1'b0;
  logic [3:0] sreg_sel = '0;
  logic [DW-1:0] wsr_data = '0;
  logic [DW-1:0] rsr_data;
  logic redirect_valid;
  logic [DW-1:0] redirect_pc;

  always #5 clk = ~clk;

  irq_sysctl #(.DW(DW), .NSRC(NSRC), .RESET_PC(RPC)) i_irq_sysctl (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .slot_valid(slot_valid),
    .slot_next_pc(slot_next_pc), .rsr_en(rsr_en), .wsr_en(wsr_en),
    .reti_en(reti_en), .sreg_sel(sreg_sel), .wsr_data(wsr_data),
    .rsr_data(rsr_data), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic m_ie, m_oie;
  logic [DW-1:0] m_iha, m_ira, m_last;
  logic [3:0] m_idn;

  function automatic logic [3:0] ref_cause(logic [NSRC-1:0] d);
    for (int i = 0; i < NSRC; i++) if (d[i]) return 4'(i + 1);
    return 4'hF;
  endfunction

  function automatic logic [DW-1:0] ref_read(logic [3:0] s);
    case (s)
      4'd0: return {30'b0, m_oie, m_ie};
      4'd1: return m_iha;
      4'd2: return m_ira;
      4'd3: return {28'b0, m_idn};
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(logic [NSRC-1:0] d, logic sv, logic [DW-1:0] npc,
                      logic rs, logic ws, logic rt, logic [3:0] sel,
                      logic [DW-1:0] wd, string tag);
    logic tk;
    logic [DW-1:0] e_rpc, e_rd;
    string t;
    @(negedge clk);
    dev_irq = d; slot_valid = sv; slot_next_pc = npc;
    rsr_en = rs; wsr_en = ws; reti_en = rt; sreg_sel = sel; wsr_data = wd;
    tk = m_ie && (|d) && !ws && !rt;
    e_rpc = tk ? m_iha : m_ira;
    e_rd = rs ? ref_read(sel) : '0;
    t = tag;
    if (tag == "RND") t = tk ? "R7" : rt ? "R8" : rs ? "R10" : "R3";
    if (tk) begin
      m_oie = m_ie; m_ie = 1'b0;
      m_ira = sv ? npc : m_last;
      m_idn = ref_cause(d);
    end else if (rt) m_ie = m_oie;
    else if (ws) begin
      case (sel)
        4'd0: begin m_ie = wd[0]; m_oie = wd[1]; end
        4'd1: m_iha = wd;
        4'd2: m_ira = wd;
        4'd3: m_idn = wd[3:0];
        default: ;
      endcase
    end
    if (sv) m_last = npc;
    @(posedge clk); #1;
    check(t, "redirect_valid", DW'(redirect_valid), DW'(tk || rt));
    if (tk || rt) check(t, "redirect_pc", redirect_pc, e_rpc);
    check(t, "rsr_data", rsr_data, e_rd);
    dev_irq = '0; rsr_en = 0; wsr_en = 0; reti_en = 0;
  endtask

  task automatic rd(logic [3:0] s, string tag);
    step('0, 1'b0, '0, 1'b1, 1'b0, 1'b0, s, '0, tag);
  endtask

  task automatic wr(logic [3:0] s, logic [DW-1:0] v, logic [NSRC-1:0] d, string tag);
    step(d, 1'b0, '0, 1'b0, 1'b1, 1'b0, s, v, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_ie = 0; m_oie = 0; m_iha = '0; m_ira = '0; m_idn = 4'hF; m_last = RPC;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1", "redirect_valid", DW'(redirect_valid), '0);
    rd(4'd0, "R1"); rd(4'd1, "R1"); rd(4'd2, "R1"); rd(4'd3, "R1");
    // register map and reserved numbers
    wr(4'd1, 32'h0000_0100, '0, "R2"); rd(4'd1, "R2");
    wr(4'd7, 32'hDEAD_BEEF, '0, "R2"); rd(4'd7, "R2");
    wr(4'd0, 32'hFFFF_FFFD, '0, "R2"); rd(4'd0, "R2");
    // last valid PC, then a bubble with two requests pending
    step('0, 1'b1, 32'h0000_1234, 0, 0, 0, 4'd0, '0, "R6");
    step(3'b110, 1'b0, 32'h0000_9999, 0, 0, 0, 4'd0, '0, "R5");
    rd(4'd0, "R4"); rd(4'd3, "R5"); rd(4'd2, "R6");
    // requests held while IE is low
    repeat (3) step(3'b111, 1'b1, 32'h0000_2000, 0, 0, 0, 4'd0, '0, "R9");
    // return: IE restored from OIE, redirect to saved address
    step('0, 1'b0, '0, 0, 0, 1, 4'd0, '0, "R8");
    rd(4'd0, "R8");
    // clearing IE beside a request blocks entry
    wr(4'd0, 32'h0, 3'b001, "R9");
    step(3'b001, 1'b0, '0, 0, 0, 0, 4'd0, '0, "R9");
    // enabled with a single request: direct entry
    wr(4'd0, 32'h1, '0, "R3");
    step(3'b100, 1'b1, 32'h0000_0500, 0, 0, 0, 4'd0, '0, "R7");
    rd(4'd3, "R5");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [NSRC-1:0] d;
      op = int'($urandom % 10);
      d = ($urandom % 3 == 0) ? NSRC'($urandom) : '0;
      step(d, 1'($urandom), $urandom, op == 2, op == 0 || op == 1, op == 3,
           ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 4),
           (op == 1) ? 32'h1 : $urandom, "RND");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule